// File: doc/BRIEF.md
# Three-Level PWM Decoder with Low-Side Diode Emulation

This block sits between a pair of window comparators on a three-level PWM line and the gate-drive stage of a synchronous buck phase. Two flags describe the PWM line: one says the line is above the upper threshold, the other says it is below the lower threshold. The block synchronizes both flags and decodes them into a registered drive command: high side on, low side on, or shutdown with both switches off.

When the line sits between the thresholds, the block keeps the last command for a programmable holdoff. If the line is still in the middle window after that, the command becomes shutdown. Leaving the window ends the shutdown on the next decode.

A separate low-side permit output gates the low switch. In continuous conduction mode the permit simply follows the low command. When the light-load input is high, the block works in diode-emulation mode. In that mode the permit is removed when the inductor current reaches zero, or when the line enters the middle window. The removal waits until the low side has been on for a minimum number of cycles, and the permit then stays off until the next low-side turn-on.

Top module: `pwm3_dem_decoder`

## Requirements
- R1: While reset is asserted and directly after it, the drive command is shutdown (2'b00) and the low-side permit is 0.
- R2: Each comparator flag passes through a two-flop synchronizer. A flag change that is stable before rising edge k shows on the drive command just after rising edge k+2.
- R3: The drive command uses three codes: 2'b01 when only the above-threshold flag is set (high side), 2'b10 when only the below-threshold flag is set (low side), and 2'b00 for shutdown. The code 2'b11 never appears.
- R4: While the decoded level is middle window (neither flag set), the command keeps its previous value. On the HOLDOFF_CYC-th consecutive middle decode it becomes shutdown.
- R5: Both flags set at once is decoded exactly as middle window, and the same holdoff applies.
- R6: The first decode of a high or low level after a shutdown sets the matching command on that same edge.
- R7: With light-load low, the permit equals (command == 2'b10) on every cycle, and the zero-crossing input has no effect.
- R8: With light-load high, the permit rises with each low-side turn-on. It falls on a zero crossing only once it has been high for at least MIN_ON_CYC cycles. It then stays low until the next turn-on, even if the zero-crossing input is removed.
- R9: With light-load high, a low-to-middle transition removes the permit once MIN_ON_CYC on-cycles have passed, even though the command stays at low side until the holdoff expires.
- R10: The permit is never high unless the command is 2'b10, in either mode.
- R11: The minimum on-time count restarts at every low-side turn-on, so each low phase in diode emulation keeps the permit for at least MIN_ON_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_above_i | input | 1 | Comparator flag: PWM line above the upper threshold (asynchronous) |
| pwm_below_i | input | 1 | Comparator flag: PWM line below the lower threshold (asynchronous) |
| light_load_i | input | 1 | Selects diode-emulation mode when high |
| zero_cross_i | input | 1 | Inductor current has reached zero |
| drive_cmd_o | output | 2 | Drive command: 00 shutdown, 01 high side, 10 low side |
| ls_permit_o | output | 1 | Low-side gate permit |

## Verification
The hardest case to reach from the ports is a zero crossing that arrives while the minimum on-time is still running. Because of the three-edge synchronizer latency, a short zero-crossing pulse tends to land either before the turn-on or after the counter has expired. The stimulus avoids this by holding the zero-crossing input high through the whole low phase, so the cut point depends on the on-time counter alone. The permit is then measured as a run length of exactly MIN_ON_CYC. The same hold-it-high approach is used for a low-to-middle transition in diode emulation and for a back-to-back low phase after a short high pulse, where the count must restart. Long randomized segments then mix levels, modes and zero crossings against a cycle-accurate behavioural model.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    // drive command codes seen at the block output
    typedef enum logic [1:0] {
        CMD_OFF  = 2'b00,
        CMD_HIGH = 2'b01,
        CMD_LOW  = 2'b10
    } drv_cmd_e;

    // decoded level of the three-state line
    typedef enum logic [1:0] {
        LVL_MID  = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_LOW  = 2'b10
    } pwm_lvl_e;

    function automatic pwm_lvl_e decode_level(input logic above, input logic below);
        pwm_lvl_e lvl;
        if (above && !below)      lvl = LVL_HIGH;
        else if (below && !above) lvl = LVL_LOW;
        else                      lvl = LVL_MID;   // neither, or the illegal both-set code
        return lvl;
    endfunction

endpackage

// File: rtl/pwm3_sync.sv
module pwm3_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = async_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pwm3_holdoff.sv
module pwm3_holdoff
    import pwm3_pkg::*;
#(
    parameter int HOLDOFF_CYC = 60
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     above_i,
    input  logic     below_i,
    output drv_cmd_e cmd_next_o,
    output drv_cmd_e cmd_o,
    output logic     lvl_mid_o
);

    localparam int CW = $clog2(HOLDOFF_CYC + 1);
    localparam logic [CW-1:0] HOLD_CAP  = CW'(HOLDOFF_CYC);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLDOFF_CYC - 1);

    typedef struct packed {
        drv_cmd_e        cmd;
        logic [CW-1:0]   mid_cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;
    pwm_lvl_e lvl;

    always_comb begin
        st_d = st_q;
        lvl  = decode_level(above_i, below_i);
        case (lvl)
            LVL_HIGH: begin
                st_d.mid_cnt = '0;
                st_d.cmd     = CMD_HIGH;
            end
            LVL_LOW: begin
                st_d.mid_cnt = '0;
                st_d.cmd     = CMD_LOW;
            end
            default: begin
                if (st_q.mid_cnt != HOLD_CAP) st_d.mid_cnt = st_q.mid_cnt + 1'b1;
                if (st_q.mid_cnt >= HOLD_LAST) st_d.cmd = CMD_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmd     <= CMD_OFF;
            st_q.mid_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_next_o = st_d.cmd;
    assign cmd_o      = st_q.cmd;
    assign lvl_mid_o  = (lvl == LVL_MID);

endmodule

// File: rtl/pwm3_lowside.sv
module pwm3_lowside
    import pwm3_pkg::*;
#(
    parameter int MIN_ON_CYC = 35
) (
    input  logic     clk,
    input  logic     rst_n,
    input  drv_cmd_e cmd_next_i,
    input  drv_cmd_e cmd_i,
    input  logic     lvl_mid_i,
    input  logic     light_load_i,
    input  logic     zero_cross_i,
    output logic     permit_o
);

    localparam int OW = $clog2(MIN_ON_CYC + 1);
    localparam logic [OW-1:0] MIN_CAP = OW'(MIN_ON_CYC);
    localparam logic [OW-1:0] ONE     = OW'(1);

    typedef struct packed {
        logic          permit;
        logic [OW-1:0] on_cnt;
    } ls_st_t;

    ls_st_t st_d, st_q;
    logic   min_done;
    logic   cut_req;

    always_comb begin
        st_d     = st_q;
        min_done = (st_q.on_cnt >= MIN_CAP);
        cut_req  = zero_cross_i || lvl_mid_i;

        if (cmd_next_i != CMD_LOW) begin
            st_d.permit = 1'b0;
        end else if (!light_load_i) begin
            st_d.permit = 1'b1;                  // continuous conduction
        end else if (cmd_i != CMD_LOW) begin
            st_d.permit = 1'b1;                  // fresh low-side turn-on
        end else if (st_q.permit && min_done && cut_req) begin
            st_d.permit = 1'b0;                  // emulated diode blocks
        end

        if (st_d.permit && !st_q.permit) begin
            st_d.on_cnt = ONE;
        end else if (st_q.permit && (st_q.on_cnt != MIN_CAP)) begin
            st_d.on_cnt = st_q.on_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.permit <= 1'b0;
            st_q.on_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign permit_o = st_q.permit;

endmodule

// File: rtl/pwm3_dem_decoder.sv
module pwm3_dem_decoder
    import pwm3_pkg::*;
#(
    parameter int HOLDOFF_CYC = 60,
    parameter int MIN_ON_CYC  = 35,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_above_i,
    input  logic       pwm_below_i,
    input  logic       light_load_i,
    input  logic       zero_cross_i,
    output logic [1:0] drive_cmd_o,
    output logic       ls_permit_o
);

    logic [1:0] flags_sync;
    drv_cmd_e   cmd_next;
    drv_cmd_e   cmd_cur;
    logic       lvl_mid;

    pwm3_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({pwm_above_i, pwm_below_i}),
        .sync_o  (flags_sync)
    );

    pwm3_holdoff #(
        .HOLDOFF_CYC (HOLDOFF_CYC)
    ) u_holdoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .above_i    (flags_sync[1]),
        .below_i    (flags_sync[0]),
        .cmd_next_o (cmd_next),
        .cmd_o      (cmd_cur),
        .lvl_mid_o  (lvl_mid)
    );

    pwm3_lowside #(
        .MIN_ON_CYC (MIN_ON_CYC)
    ) u_lowside (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_next_i   (cmd_next),
        .cmd_i        (cmd_cur),
        .lvl_mid_i    (lvl_mid),
        .light_load_i (light_load_i),
        .zero_cross_i (zero_cross_i),
        .permit_o     (ls_permit_o)
    );

    assign drive_cmd_o = cmd_cur;

endmodule

// File: rtl/pwm3_dem_decoder_chk.sv
module pwm3_dem_decoder_chk #(
    parameter int MIN_ON_CYC = 35
) (
    input logic       clk,
    input logic       rst_n,
    input logic       light_load_i,
    input logic [1:0] drive_cmd_o,
    input logic       ls_permit_o
);

    localparam int LW = $clog2(MIN_ON_CYC + 2);
    localparam logic [LW-1:0] LEN_CAP = LW'(MIN_ON_CYC + 1);

    logic [LW-1:0] on_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 on_len_q <= '0;
        else if (!ls_permit_o)      on_len_q <= '0;
        else if (on_len_q != LEN_CAP) on_len_q <= on_len_q + 1'b1;
    end

    // R3: the unused code never reaches the output
    a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        drive_cmd_o != 2'b11);

    // R10: permit only during a low-side command
    a_r10_permit_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        ls_permit_o |-> drive_cmd_o == 2'b10);

    // R7: continuous conduction mode tracks the command
    a_r7_ccm_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(light_load_i) |-> ls_permit_o == (drive_cmd_o == 2'b10));

    // R8: a cut inside a low phase honours the minimum on-time
    a_r8_min_on: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ls_permit_o) && drive_cmd_o == 2'b10) |-> on_len_q >= LW'(MIN_ON_CYC));

    // R8: in emulation the permit only reopens on a new turn-on
    a_r8_reopen_on_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ls_permit_o) && $past(light_load_i)) |-> $past(drive_cmd_o) != 2'b10);

endmodule

bind pwm3_dem_decoder pwm3_dem_decoder_chk #(
    .MIN_ON_CYC (MIN_ON_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .light_load_i (light_load_i),
    .drive_cmd_o  (drive_cmd_o),
    .ls_permit_o  (ls_permit_o)
);

// File: tb/tb_pwm3_dem_decoder.sv
module tb_pwm3_dem_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 20;
    localparam int MINON      = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above = 1'b0, below = 1'b0, ll = 1'b0, zc = 1'b0;
    logic [1:0] cmd;
    logic permit;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm3_dem_decoder #(
        .HOLDOFF_CYC (HOLD),
        .MIN_ON_CYC  (MINON),
        .SYNC_STAGES (2)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwm_above_i  (above),
        .pwm_below_i  (below),
        .light_load_i (ll),
        .zero_cross_i (zc),
        .drive_cmd_o  (cmd),
        .ls_permit_o  (permit)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    bit    done   = 1'b0;

    // behavioural reference: two-deep delay line plus run-length counters
    int q_hi[$];
    int q_lo[$];
    int m_cmd, m_perm, mid_run, on_run;
    int h, l, ncmd, np;
    bit is_mid;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_hi = '{0, 0};
            q_lo = '{0, 0};
            m_cmd = 0; m_perm = 0; mid_run = 0; on_run = 0;
        end else begin
            h = q_hi.pop_front();
            l = q_lo.pop_front();
            q_hi.push_back(int'(above));
            q_lo.push_back(int'(below));
            is_mid = (h == l);
            ncmd = m_cmd;
            if (is_mid) begin
                if (mid_run < 1000000) mid_run++;
                if (mid_run >= HOLD) ncmd = 0;
            end else begin
                mid_run = 0;
                ncmd = (h != 0) ? 1 : 2;
            end
            if (ncmd != 2)                                      np = 0;
            else if (!ll)                                       np = 1;
            else if (m_cmd != 2)                                np = 1;
            else if (m_perm != 0 && on_run >= MINON && (zc || is_mid)) np = 0;
            else                                                np = m_perm;
            if (np != 0 && m_perm == 0)  on_run = 1;
            else if (m_perm != 0 && on_run < 1000000) on_run++;
            m_cmd = ncmd;
            m_perm = np;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag, "cmd vs model", int'(cmd), m_cmd);
            chk(tag, "permit vs model", int'(permit), m_perm);
        end
    end

    // 0 middle, 1 high, 2 low, 3 both flags
    task automatic set_lvl(input int v);
        above = v[0];
        below = v[1];
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_perm(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (permit) c++;
        end
    endtask

    int cnt;

    initial begin
        wait_cyc(3);
        tag = "R1";
        chk("R1", "cmd in reset", int'(cmd), 0);
        chk("R1", "permit in reset", int'(permit), 0);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1", "cmd after reset", int'(cmd), 0);
        chk("R1", "permit after reset", int'(permit), 0);
        wait_cyc(HOLD + 4);

        // R2: three-edge latency from flag to command
        tag = "R2";
        set_lvl(1);
        wait_cyc(2);
        chk("R2", "cmd before sync done", int'(cmd), 0);
        wait_cyc(1);
        chk("R2", "cmd after three edges", int'(cmd), 1);

        // R3: low code, R7: permit follows in CCM, zc ignored
        tag = "R3";
        set_lvl(2);
        wait_cyc(3);
        chk("R3", "low code", int'(cmd), 2);
        tag = "R7";
        zc = 1'b1;
        wait_cyc(MINON + 4);
        chk("R7", "ccm permit with zc", int'(permit), 1);
        zc = 1'b0;

        // R4: holdoff from low side
        tag = "R4";
        set_lvl(0);
        wait_cyc(HOLD + 1);
        chk("R4", "cmd kept during holdoff", int'(cmd), 2);
        wait_cyc(1);
        chk("R4", "shutdown after holdoff", int'(cmd), 0);
        chk("R4", "permit off in shutdown", int'(permit), 0);

        // R6: release from shutdown
        tag = "R6";
        set_lvl(1);
        wait_cyc(3);
        chk("R6", "release to high", int'(cmd), 1);

        // R4: short middle burst never shuts down
        tag = "R4";
        set_lvl(0);
        wait_cyc(HOLD - 1);
        set_lvl(1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R4", "short burst keeps high", int'(cmd), 1);
        end

        // R5: both flags act as middle window
        tag = "R5";
        set_lvl(3);
        wait_cyc(HOLD + 1);
        chk("R5", "both flags held", int'(cmd), 1);
        wait_cyc(1);
        chk("R5", "both flags shutdown", int'(cmd), 0);

        // R8: zc held through the low phase, cut exactly at min on-time
        tag = "R8";
        ll = 1'b1;
        set_lvl(1);
        wait_cyc(6);
        zc = 1'b1;
        set_lvl(2);
        count_perm(MINON + 14, cnt);
        chk("R8", "permit run with early zc", cnt, MINON);
        chk("R8", "cmd stays low after cut", int'(cmd), 2);
        zc = 1'b0;
        wait_cyc(4);
        chk("R8", "permit stays off after zc clears", int'(permit), 0);

        // R8: late zero crossing cuts on the next edge
        set_lvl(1);
        wait_cyc(6);
        set_lvl(2);
        wait_cyc(MINON + 10);
        chk("R8", "permit held without zc", int'(permit), 1);
        zc = 1'b1;
        wait_cyc(1);
        zc = 1'b0;
        chk("R8", "late zc cut", int'(permit), 0);

        // R11: short high pulse between low phases restarts the count
        tag = "R11";
        zc = 1'b1;
        set_lvl(1);
        wait_cyc(5);
        set_lvl(2);
        count_perm(MINON + 10, cnt);
        chk("R11", "restarted min on-time", cnt, MINON);
        zc = 1'b0;

        // R9: low to middle in emulation cuts at min on-time, before holdoff
        tag = "R9";
        set_lvl(1);
        wait_cyc(6);
        set_lvl(2);
        wait_cyc(3);
        set_lvl(0);
        count_perm(MINON + 4, cnt);
        chk("R9", "mid cut after min on-time", cnt + 1, MINON);
        chk("R9", "cmd still low before holdoff", int'(cmd), 2);
        wait_cyc(HOLD);
        chk("R9", "shutdown after holdoff", int'(cmd), 0);

        // R10: randomized mix against the model
        tag = "R10";
        for (int s = 0; s < 300; s++) begin
            int len;
            set_lvl($urandom_range(0, 3));
            ll  = ($urandom_range(0, 2) != 0);
            len = $urandom_range(1, 30);
            for (int i = 0; i < len; i++) begin
                zc = ($urandom_range(0, 5) == 0);
                @(negedge clk);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule